// File: doc/BRIEF.md
# Write-Through Snooping Invalidation Cache Subsystem

This block is a small shared-bus multiprocessor memory subsystem. Each processor port has its own private direct-mapped cache, and each cache writes through to memory. One round-robin arbiter controls a single shared bus, and a word-addressed backing memory with fixed latency sits on that bus. Reads that hit a valid local line complete at once and never use the bus. Read misses and all writes must first win the bus.

Every write updates memory. When the write completes, the bus carries a snoop message that holds only the line address and the index of the issuing port. Every other cache that holds that line clears its valid bit, so its next read misses and fetches the current value from memory. Writes do not allocate a line. A write hit updates the writer's own line in place. When two writers target the same address together, the arbiter orders them: the first one granted invalidates and commits first.

A processor raises `req_i` with `we_i`, `addr_i` and `wdata_i`. It holds them stable until `ready_o` pulses for one cycle. For reads, `rdata_o` is valid in that same cycle.

Top module: `wt_snoop_subsys`

## Requirements
- R1: Every write completes only after a bus transaction that stores `wdata` into memory at `addr`. This holds whether or not the line is cached in the writer, and a later read miss from any port returns that value.
- R2: When a write completes, every other cache holding a valid copy of that line clears it. The next read of that address there misses (takes the bus) and returns the written value.
- R3: A cache ignores the snoop message its own write generates. On a write hit the local line is updated in place and stays a hit. A write miss does not allocate a line.
- R4: A read that hits a valid local line asserts `ready_o` in the same cycle as the request, with the cached word, and makes no bus request.
- R5: A read miss on an idle bus asserts `ready_o` exactly 2 cycles after the request cycle (1 grant cycle plus memory latency minus 1). It returns the memory word and fills the line, so that an immediate re-read hits.
- R6: At most one port holds the bus grant, and a grant is held unchanged until its transaction completes. Two writes to the same address in the same cycle complete in different cycles, and memory ends with the value of the one that completed later.
- R7: The arbiter grants in round-robin order starting after the last granted port. After reset, port 0 has the highest priority.
- R8: Two ports may hold valid copies of the same line at once after independent read misses. Both then hit.
- R9: A snoop invalidation that arrives while a read miss to the same line is waiting for the bus cannot leave stale data. A read issued after both accesses complete returns the written value.
- R10: After reset, every cache line is invalid and memory holds zero. `ready_o` is low, and the first read of any address misses and returns 0.
- R11: Lines are indexed by the low address bits (3 bits with 8 lines). A read miss to another address with the same index evicts the resident line, so a later read of the evicted address misses again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | N_PORTS | Per-port request, held until ready |
| we_i | input | N_PORTS | Per-port write enable |
| addr_i | input | N_PORTS x 8 | Per-port word address |
| wdata_i | input | N_PORTS x 32 | Per-port write data |
| rdata_o | output | N_PORTS x 32 | Per-port read data, valid with ready |
| ready_o | output | N_PORTS | Per-port one-cycle completion pulse |

## Verification
The assertions check four properties on every cycle. The grant is one-hot and stays stable through a transaction. A granted read is never a local hit. Every completed write shows up in memory on the next cycle. A matching foreign snoop clears the line, and a completed read miss fills it. Only the bench's scenarios can show the remaining properties at the ports: hit and miss latencies, the rotation order among simultaneous requesters, how same-address writers resolve, eviction on an index conflict, and that a reader whose copy was invalidated returns fresh data.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;
endpackage

// File: rtl/wt_arbiter.sv
module wt_arbiter #(
  parameter int unsigned N_PORTS = 4,
  localparam int unsigned IDX_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PORTS-1:0] req_i,
  input  logic               done_i,
  output logic [N_PORTS-1:0] gnt_o,
  output logic [IDX_W-1:0]   gnt_idx_o,
  output logic               busy_o
);
  logic [N_PORTS-1:0] gnt_q;
  logic [IDX_W-1:0]   last_q, pick;
  logic               found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int k = 1; k <= int'(N_PORTS); k++) begin
      int idx;
      idx = (int'(last_q) + k) % int'(N_PORTS);
      if (!found && req_i[idx]) begin
        pick  = IDX_W'(idx);
        found = 1'b1;
      end
    end
  end

  assign busy_o    = |gnt_q;
  assign gnt_o     = gnt_q;
  assign gnt_idx_o = last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q  <= '0;
      last_q <= IDX_W'(N_PORTS - 1);
    end else if (!busy_o) begin
      if (found) begin
        gnt_q  <= N_PORTS'(1) << pick;
        last_q <= pick;
      end
    end else if (done_i) begin
      gnt_q <= '0;
    end
  end

  assert_gnt_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q));
  assert_gnt_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_i) |=> $stable(gnt_q));
endmodule

// File: rtl/wt_memory.sv
module wt_memory
  import snoop_pkg::*;
#(
  parameter int unsigned MEM_LAT = 2,
  localparam int unsigned DEPTH  = 1 << ADDR_W,
  localparam int unsigned CNT_W  = $clog2(MEM_LAT) + 1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  busy_i,
  input  logic  we_i,
  input  addr_t addr_i,
  input  data_t wdata_i,
  output data_t rdata_o,
  output logic  done_o
);
  data_t            mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  assign done_o  = busy_i && (cnt_q == CNT_W'(MEM_LAT - 1));
  assign rdata_o = mem_q[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (busy_i) cnt_q <= done_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (done_o && we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assert_write_lands_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && we_i) |=> (mem_q[$past(addr_i)] == $past(wdata_i)));
endmodule

// File: rtl/wt_cache.sv
module wt_cache
  import snoop_pkg::*;
#(
  parameter int unsigned ID      = 0,
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned LINES   = 8,
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned TAG_W  = ADDR_W - IDX_W,
  localparam int unsigned SRC_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  addr_t            addr_i,
  input  data_t            wdata_i,
  output data_t            rdata_o,
  output logic             ready_o,
  output logic             bus_req_o,
  input  logic             gnt_i,
  input  logic             done_i,
  input  data_t            bus_rdata_i,
  input  logic             inv_valid_i,
  input  addr_t            inv_addr_i,
  input  logic [SRC_W-1:0] inv_src_i
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q  [LINES];
  data_t            data_q [LINES];

  logic [IDX_W-1:0] idx, inv_idx;
  logic [TAG_W-1:0] tag, inv_tag;
  logic             hit, own_done, inv_hit;

  assign idx      = addr_i[IDX_W-1:0];
  assign tag      = addr_i[ADDR_W-1:IDX_W];
  assign inv_idx  = inv_addr_i[IDX_W-1:0];
  assign inv_tag  = inv_addr_i[ADDR_W-1:IDX_W];
  assign hit      = valid_q[idx] && (tag_q[idx] == tag);
  assign own_done = gnt_i && done_i;
  assign inv_hit  = inv_valid_i && (inv_src_i != SRC_W'(ID)) &&
                    valid_q[inv_idx] && (tag_q[inv_idx] == inv_tag);

  // request is held stable by the processor, so no request latch is needed
  assign bus_req_o = req_i && (we_i || !hit);
  assign ready_o   = own_done || (req_i && !we_i && hit);
  assign rdata_o   = own_done ? bus_rdata_i : data_q[idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < int'(LINES); i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      if (inv_hit) valid_q[inv_idx] <= 1'b0;
      if (own_done) begin
        if (!we_i) begin
          valid_q[idx] <= 1'b1;
          tag_q[idx]   <= tag;
          data_q[idx]  <= bus_rdata_i;
        end else if (hit) begin
          data_q[idx] <= wdata_i;
        end
      end
    end
  end

  assert_granted_read_misses_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i && req_i && !we_i) |-> !hit);
  assert_snoop_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_hit |=> !valid_q[$past(inv_idx)]);
  assert_miss_fills_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_done && !we_i) |=> valid_q[$past(idx)]);
endmodule

// File: rtl/wt_snoop_subsys.sv
module wt_snoop_subsys
  import snoop_pkg::*;
#(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned LINES   = 8,
  parameter int unsigned MEM_LAT = 2,
  localparam int unsigned SRC_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_PORTS-1:0]             req_i,
  input  logic [N_PORTS-1:0]             we_i,
  input  logic [N_PORTS-1:0][ADDR_W-1:0] addr_i,
  input  logic [N_PORTS-1:0][DATA_W-1:0] wdata_i,
  output logic [N_PORTS-1:0][DATA_W-1:0] rdata_o,
  output logic [N_PORTS-1:0]             ready_o
);
  logic [N_PORTS-1:0] bus_req, gnt;
  logic [SRC_W-1:0]   gnt_idx;
  logic               busy, done;
  addr_t              bus_addr;
  data_t              bus_wdata, bus_rdata;
  logic               bus_we, inv_valid;

  // granted port keeps its request stable, so the bus is muxed from its inputs
  assign bus_addr  = addr_i[gnt_idx];
  assign bus_wdata = wdata_i[gnt_idx];
  assign bus_we    = we_i[gnt_idx];
  assign inv_valid = done && bus_we;

  wt_arbiter #(.N_PORTS(N_PORTS)) u_arb (
    .clk_i, .rst_ni, .req_i(bus_req), .done_i(done),
    .gnt_o(gnt), .gnt_idx_o(gnt_idx), .busy_o(busy)
  );

  wt_memory #(.MEM_LAT(MEM_LAT)) u_mem (
    .clk_i, .rst_ni, .busy_i(busy), .we_i(bus_we), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata), .done_o(done)
  );

  for (genvar p = 0; p < int'(N_PORTS); p++) begin : g_port
    wt_cache #(.ID(p), .N_PORTS(N_PORTS), .LINES(LINES)) u_cache (
      .clk_i, .rst_ni,
      .req_i(req_i[p]), .we_i(we_i[p]), .addr_i(addr_i[p]), .wdata_i(wdata_i[p]),
      .rdata_o(rdata_o[p]), .ready_o(ready_o[p]), .bus_req_o(bus_req[p]),
      .gnt_i(gnt[p]), .done_i(done), .bus_rdata_i(bus_rdata),
      .inv_valid_i(inv_valid), .inv_addr_i(bus_addr), .inv_src_i(gnt_idx)
    );
  end
endmodule

// File: tb/tb_wt_snoop_subsys.sv
module tb_wt_snoop_subsys;
  localparam int NP = 4;
  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NP-1:0]        req = '0, we = '0;
  logic [NP-1:0][7:0]   addr = '0;
  logic [NP-1:0][31:0]  wdata = '0;
  logic [NP-1:0][31:0]  rdata;
  logic [NP-1:0]        ready;
  int checks = 0, fails = 0, cyc = 0;
  int done_cyc [NP];
  int last_gnt = NP - 1;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wt_snoop_subsys dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic acc(input int p, input bit w, input logic [7:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output int lat);
    @(negedge clk);
    req[p] = 1'b1; we[p] = w; addr[p] = a; wdata[p] = d;
    lat = 0;
    forever begin
      #1;
      if (ready[p]) break;
      @(negedge clk);
      lat++;
    end
    rd = rdata[p];
    done_cyc[p] = cyc;
    if (lat > 0) last_gnt = p;
    @(posedge clk);
    #1 req[p] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] rd; int lat;
    chk(ready == '0, "R10 ready low", int'(ready), 0);
    acc(0, 0, 8'h10, 0, rd, lat);
    chk(rd == 0, "R10 mem zero", rd, 0);
    chk(lat == 2, "R10/R5 first read misses", lat, 2);
  endtask

  task automatic t_miss_hit_share();
    logic [31:0] rd; int lat;
    acc(2, 1, 8'h21, 32'd7, rd, lat);
    chk(lat == 2, "R1 write takes bus", lat, 2);
    acc(0, 0, 8'h21, 0, rd, lat);
    chk(rd == 7 && lat == 2, "R5 miss returns mem", rd, 7);
    acc(1, 0, 8'h21, 0, rd, lat);
    chk(rd == 7 && lat == 2, "R8 second reader misses", rd, 7);
    acc(0, 0, 8'h21, 0, rd, lat);
    chk(rd == 7 && lat == 0, "R4 hit immediate p0", lat, 0);
    acc(1, 0, 8'h21, 0, rd, lat);
    chk(rd == 7 && lat == 0, "R8 shared copy hits p1", lat, 0);
  endtask

  task automatic t_invalidate();
    logic [31:0] rd; int lat;
    acc(0, 1, 8'h21, 32'd100, rd, lat);
    chk(lat == 2, "R1 write hit still on bus", lat, 2);
    acc(1, 0, 8'h21, 0, rd, lat);
    chk(lat == 2, "R2 invalidated reader misses", lat, 2);
    chk(rd == 100, "R2 fresh value", rd, 100);
    acc(0, 0, 8'h21, 0, rd, lat);
    chk(lat == 0 && rd == 100, "R3 own line kept and updated", rd, 100);
  endtask

  task automatic t_no_alloc();
    logic [31:0] rd; int lat;
    acc(3, 1, 8'h35, 32'd55, rd, lat);
    acc(3, 0, 8'h35, 0, rd, lat);
    chk(lat == 2, "R3 write miss not allocated", lat, 2);
    chk(rd == 55, "R1 write miss reached memory", rd, 55);
  endtask

  task automatic t_conflict_index();
    logic [31:0] rd; int lat;
    acc(2, 1, 8'h4B, 32'd11, rd, lat);
    acc(2, 1, 8'h8B, 32'd22, rd, lat);
    acc(1, 0, 8'h4B, 0, rd, lat);
    acc(1, 0, 8'h8B, 0, rd, lat);
    chk(rd == 22 && lat == 2, "R11 same-index other tag misses", rd, 22);
    acc(1, 0, 8'h4B, 0, rd, lat);
    chk(rd == 11 && lat == 2, "R11 evicted line misses again", lat, 2);
  endtask

  task automatic t_same_addr_writers();
    logic [31:0] r1, r2, rd; int l1, l2, lat; int exp;
    fork
      acc(1, 1, 8'h60, 32'd201, r1, l1);
      acc(2, 1, 8'h60, 32'd202, r2, l2);
    join
    chk(done_cyc[1] != done_cyc[2], "R6 writers serialised", done_cyc[1], done_cyc[2]);
    exp = (done_cyc[1] > done_cyc[2]) ? 201 : 202;
    acc(3, 0, 8'h60, 0, rd, lat);
    chk(rd == exp, "R6 later writer wins", rd, exp);
  endtask

  task automatic t_round_robin();
    logic [31:0] r0, r1, r2, r3; int l0, l1, l2, l3;
    int start;
    start = (last_gnt + 1) % NP;
    fork
      acc(0, 1, 8'h70, 32'd1, r0, l0);
      acc(1, 1, 8'h71, 32'd2, r1, l1);
      acc(2, 1, 8'h72, 32'd3, r2, l2);
      acc(3, 1, 8'h73, 32'd4, r3, l3);
    join
    for (int k = 0; k < NP - 1; k++) begin
      int a, b;
      a = (start + k) % NP;
      b = (start + k + 1) % NP;
      chk(done_cyc[a] < done_cyc[b], "R7 rotation order", done_cyc[a], done_cyc[b]);
    end
  endtask

  task automatic t_pending_miss();
    logic [31:0] r0, r3, rd; int l0, l3, lat;
    acc(3, 0, 8'h90, 0, rd, lat);
    fork
      acc(0, 1, 8'h90, 32'd77, r0, l0);
      acc(3, 0, 8'h90, 0, r3, l3);
    join
    acc(3, 0, 8'h90, 0, rd, lat);
    chk(rd == 77, "R9 no stale data after racing snoop", rd, 77);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_miss_hit_share();
        t_invalidate();
        t_no_alloc();
        t_conflict_index();
        t_same_addr_writers();
        t_round_robin();
        t_pending_miss();
      end
      begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", cyc, 0);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule